// File: doc/BRIEF.md
# Two-Port Synchronous Memory with Per-Port Read Latency

This block is a word-addressed memory with two fully independent ports. Each port has its own clock, and in any cycle either port may read or write any word, including the word the other port is using. A word is two byte lanes wide. Every write or read can be limited to the lower lane, the upper lane or both by active-low lane selects.

Each port has a two-signal select: an active-low enable and an active-high enable. Each port also has a latency input that picks its read timing. With the latency input low, read data appears after the clock edge that captured the read. With it high, an extra register stage adds one clock of delay. The tristate bus of a discrete memory is replaced by a data-out vector and a per-lane drive-enable vector. The output enable gates the drive enables without waiting for a clock. A surrounding bus fabric uses the drive enables to steer or merge the read data.

Top module: `sync_dual_port_mem`

## Requirements
- R1: A port is selected only when its `*_cs0_n` input is 0 and its `*_cs1` input is 1. Any other combination neither writes the memory nor turns on the port's drive enables.
- R2: A selected port with `*_we_n` = 0 writes `*_wdata` into the addressed word. Only lanes whose select is 0 are written: `*_lo_n` controls bits [LANE_W-1:0] and `*_hi_n` controls bits [2*LANE_W-1:LANE_W]. A lane whose select is 1 keeps its old value.
- R3: With `*_pipe` = 0, a selected read (`*_we_n` = 1) sampled on edge k presents the addressed word on `*_rdata` after edge k.
- R4: With `*_pipe` = 1, the same read presents its data and drive enables after edge k+1, exactly one edge later than in R3.
- R5: Drive enable bit 0 covers the lower lane and bit 1 the upper lane. A bit is 1 only for a selected read whose lane select was 0 in that read's cycle. Write cycles turn on no drive enable.
- R6: `*_oe_n` = 1 forces both drive enables of its port to 0 at once, with no clock edge. Returning it to 0 restores the enables that the registered state calls for.
- R7: A deselected cycle turns the drive enables off after the next edge when `*_pipe` = 0, and one edge later when `*_pipe` = 1. A single selected read cycle is enough to drive again.
- R8: Both ports work at the same time without interfering. A read of a word that the other port writes on the same edge returns the old contents. The new contents are returned from the next access onward.
- R9: When both ports write the same word on the same edge, lanes written by both hold an undefined value. A lane written by only one port holds that port's data.
- R10: While `rst_n` is 0, both ports' drive enables are 0. This takes effect immediately and does not wait for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the output stages |
| a_clk | input | 1 | Port A clock |
| a_cs0_n | input | 1 | Port A active-low select |
| a_cs1 | input | 1 | Port A active-high select |
| a_we_n | input | 1 | Port A write (0) / read (1) |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | 2*LANE_W | Port A write data |
| a_lo_n | input | 1 | Port A lower-lane select, active low |
| a_hi_n | input | 1 | Port A upper-lane select, active low |
| a_oe_n | input | 1 | Port A output enable, active low, unclocked |
| a_pipe | input | 1 | Port A latency: 0 direct, 1 one extra stage |
| a_rdata | output | 2*LANE_W | Port A read data |
| a_drv | output | 2 | Port A per-lane drive enable |
| b_clk | input | 1 | Port B clock |
| b_cs0_n | input | 1 | Port B active-low select |
| b_cs1 | input | 1 | Port B active-high select |
| b_we_n | input | 1 | Port B write (0) / read (1) |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | 2*LANE_W | Port B write data |
| b_lo_n | input | 1 | Port B lower-lane select, active low |
| b_hi_n | input | 1 | Port B upper-lane select, active low |
| b_oe_n | input | 1 | Port B output enable, active low, unclocked |
| b_pipe | input | 1 | Port B latency: 0 direct, 1 one extra stage |
| b_rdata | output | 2*LANE_W | Port B read data |
| b_drv | output | 2 | Port B per-lane drive enable |

## Verification
The bench targets reads of a word the other port writes on the same edge. A design that forwarded the new data, or corrupted the storage encoding, would return the wrong old value there.

It also covers same-edge writes to disjoint lanes of one word. If the ports' contributions leak across lanes, the lane written by only one port reads back as garbage.

Deselect and reactivation are exercised in both latency modes. A design that took its pipelined drive from the current cycle's controls would switch off or turn back on one edge too early.

Lane selects and the unclocked output enable are toggled between clock edges and during reads. Drive enables that latched the wrong cycle's lane selects, or that waited for a clock before obeying the output enable, would show up there.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

  // Number of byte lanes in one word
  localparam int NLANE = 2;

  // Two-signal port select: active-low enable and active-high enable
  function automatic logic port_sel(input logic cs0_n, input logic cs1);
    return (!cs0_n) && cs1;
  endfunction

  // Active-low lane selects to an active-high lane mask, bit 0 = lower lane
  function automatic logic [NLANE-1:0] lane_mask(input logic lo_n, input logic hi_n);
    return {!hi_n, !lo_n};
  endfunction

  // Drive enables seen at the port: output enable gates a registered lane mask
  function automatic logic [NLANE-1:0] drive_of(input logic oe_n, input logic valid,
                                                input logic [NLANE-1:0] lanes);
    return (oe_n || !valid) ? '0 : lanes;
  endfunction

endpackage

// File: rtl/dpm_bank.sv
module dpm_bank import dpm_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [NLANE-1:0]        wr_lanes,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [NLANE*LANE_W-1:0] wr_word,
  input  logic [ADDR_W-1:0]       own_addr,
  input  logic [ADDR_W-1:0]       oth_addr,
  output logic [NLANE*LANE_W-1:0] own_word,
  output logic [NLANE*LANE_W-1:0] oth_word
);
  localparam int DW    = NLANE * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  // One bank per writing port; only this port's clock ever writes here
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < NLANE; l++) begin
        if (wr_lanes[l]) store[wr_addr][l*LANE_W +: LANE_W] <= wr_word[l*LANE_W +: LANE_W];
      end
    end
  end

  assign own_word = store[own_addr];
  assign oth_word = store[oth_addr];

endmodule

// File: rtl/dpm_out.sv
module dpm_out import dpm_pkg::*; #(
  parameter int DW = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_fire,
  input  logic [NLANE-1:0] rd_lanes,
  input  logic [DW-1:0]    rd_word,
  input  logic             pipe,
  input  logic             oe_n,
  output logic [DW-1:0]    rdata,
  output logic [NLANE-1:0] drv,
  output logic [DW-1:0]    ft_word
);
  // Stage 1: direct path; stage 2: extra register for the pipelined mode
  logic             s1_valid, s2_valid;
  logic [NLANE-1:0] s1_lanes, s2_lanes;
  logic [DW-1:0]    s1_word, s2_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_lanes <= '0;
      s1_word  <= '0;
      s2_valid <= 1'b0;
      s2_lanes <= '0;
      s2_word  <= '0;
    end else begin
      s1_valid <= rd_fire;
      s1_lanes <= rd_fire ? rd_lanes : '0;
      s1_word  <= rd_word;
      s2_valid <= s1_valid;
      s2_lanes <= s1_lanes;
      s2_word  <= s1_word;
    end
  end

  logic             sel_valid;
  logic [NLANE-1:0] sel_lanes;
  assign sel_valid = pipe ? s2_valid : s1_valid;
  assign sel_lanes = pipe ? s2_lanes : s1_lanes;
  assign rdata     = pipe ? s2_word  : s1_word;
  assign ft_word   = s1_word;

  // Output enable and reset act without a clock
  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assign drv[l] = rst_n && drive_of(oe_n, sel_valid, sel_lanes)[l];
  end

endmodule

// File: rtl/sync_dual_port_mem.sv
module sync_dual_port_mem import dpm_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9
) (
  input  logic                    rst_n,
  input  logic                    a_clk,
  input  logic                    a_cs0_n,
  input  logic                    a_cs1,
  input  logic                    a_we_n,
  input  logic [ADDR_W-1:0]       a_addr,
  input  logic [2*LANE_W-1:0]     a_wdata,
  input  logic                    a_lo_n,
  input  logic                    a_hi_n,
  input  logic                    a_oe_n,
  input  logic                    a_pipe,
  output logic [2*LANE_W-1:0]     a_rdata,
  output logic [1:0]              a_drv,
  input  logic                    b_clk,
  input  logic                    b_cs0_n,
  input  logic                    b_cs1,
  input  logic                    b_we_n,
  input  logic [ADDR_W-1:0]       b_addr,
  input  logic [2*LANE_W-1:0]     b_wdata,
  input  logic                    b_lo_n,
  input  logic                    b_hi_n,
  input  logic                    b_oe_n,
  input  logic                    b_pipe,
  output logic [2*LANE_W-1:0]     b_rdata,
  output logic [1:0]              b_drv
);
  localparam int DW = NLANE * LANE_W;
  localparam int NP = 2;

  logic [NP-1:0]    clk_v, cs0n_v, cs1_v, we_v, lo_v, hi_v, oe_v, pipe_v;
  logic [ADDR_W-1:0] addr_v [NP];
  logic [DW-1:0]     wdata_v [NP];
  logic [DW-1:0]     own_rd [NP];
  logic [DW-1:0]     oth_rd [NP];
  logic [DW-1:0]     enc_word [NP];
  logic [DW-1:0]     cur_word [NP];
  logic [DW-1:0]     rdata_v [NP];
  logic [DW-1:0]     ft_word_v [NP];
  logic [NLANE-1:0]  lane_v [NP];
  logic [NLANE-1:0]  drv_v [NP];

  // Named internal events, observed by the bound checker
  logic [NP-1:0] sel, rd_fire, wr_fire;
  logic [DW-1:0] a_ft_word, b_ft_word;

  assign clk_v  = {b_clk,   a_clk};
  assign cs0n_v = {b_cs0_n, a_cs0_n};
  assign cs1_v  = {b_cs1,   a_cs1};
  assign we_v   = {b_we_n,  a_we_n};
  assign lo_v   = {b_lo_n,  a_lo_n};
  assign hi_v   = {b_hi_n,  a_hi_n};
  assign oe_v   = {b_oe_n,  a_oe_n};
  assign pipe_v = {b_pipe,  a_pipe};
  assign addr_v[0]  = a_addr;
  assign addr_v[1]  = b_addr;
  assign wdata_v[0] = a_wdata;
  assign wdata_v[1] = b_wdata;

  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam int Q = NP - 1 - p;

    assign sel[p]     = port_sel(cs0n_v[p], cs1_v[p]);
    assign lane_v[p]  = lane_mask(lo_v[p], hi_v[p]);
    assign wr_fire[p] = sel[p] && !we_v[p];
    assign rd_fire[p] = sel[p] && we_v[p];

    // Stored word = bank A ^ bank B; a write cancels the other bank's share
    assign enc_word[p] = wdata_v[p] ^ oth_rd[Q];
    assign cur_word[p] = own_rd[p] ^ oth_rd[Q];

    dpm_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
      .clk      (clk_v[p]),
      .wr_en    (wr_fire[p]),
      .wr_lanes (lane_v[p]),
      .wr_addr  (addr_v[p]),
      .wr_word  (enc_word[p]),
      .own_addr (addr_v[p]),
      .oth_addr (addr_v[Q]),
      .own_word (own_rd[p]),
      .oth_word (oth_rd[p])
    );

    dpm_out #(.DW(DW)) u_out (
      .clk      (clk_v[p]),
      .rst_n    (rst_n),
      .rd_fire  (rd_fire[p]),
      .rd_lanes (lane_v[p]),
      .rd_word  (cur_word[p]),
      .pipe     (pipe_v[p]),
      .oe_n     (oe_v[p]),
      .rdata    (rdata_v[p]),
      .drv      (drv_v[p]),
      .ft_word  (ft_word_v[p])
    );
  end

  assign a_rdata   = rdata_v[0];
  assign b_rdata   = rdata_v[1];
  assign a_drv     = drv_v[0];
  assign b_drv     = drv_v[1];
  assign a_ft_word = ft_word_v[0];
  assign b_ft_word = ft_word_v[1];

endmodule

// File: rtl/dpm_chk.sv
module dpm_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic          we_n,
  input logic          lo_n,
  input logic          hi_n,
  input logic          oe_n,
  input logic          pipe,
  input logic [1:0]    drv,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] ft_word
);

  AST_OE_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (drv == 2'b00)); // R6

  AST_DESEL_OFF_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && $past(!sel)) |-> (drv == 2'b00)); // R7

  AST_DESEL_OFF_PIPED: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe && $past(!sel, 2)) |-> (drv == 2'b00)); // R7

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && $past(sel && !we_n)) |-> (drv == 2'b00)); // R5

  AST_LO_LANE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && drv[0]) |-> $past(sel && we_n && !lo_n)); // R5

  AST_HI_LANE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && drv[1]) |-> $past(sel && we_n && !hi_n)); // R5

  AST_PIPE_ONE_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    pipe |-> (rdata == $past(ft_word))); // R4

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (drv == 2'b00)); // R10

endmodule

bind sync_dual_port_mem dpm_chk #(.DW(2*LANE_W)) u_chk_a (
  .clk(a_clk), .rst_n(rst_n), .sel(sel[0]), .we_n(a_we_n), .lo_n(a_lo_n), .hi_n(a_hi_n),
  .oe_n(a_oe_n), .pipe(a_pipe), .drv(a_drv), .rdata(a_rdata), .ft_word(a_ft_word)
);

bind sync_dual_port_mem dpm_chk #(.DW(2*LANE_W)) u_chk_b (
  .clk(b_clk), .rst_n(rst_n), .sel(sel[1]), .we_n(b_we_n), .lo_n(b_lo_n), .hi_n(b_hi_n),
  .oe_n(b_oe_n), .pipe(b_pipe), .drv(b_drv), .rdata(b_rdata), .ft_word(b_ft_word)
);

// File: tb/sim_sync_dual_port_mem.sv
`timescale 1ns/1ps
module sim_sync_dual_port_mem;
  localparam int AW = 10;
  localparam int LW = 9;
  localparam int DW = 2 * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] cs0_n, cs1, we_n, lo_n, hi_n, oe_n, pipe;
  logic [AW-1:0] addr [2];
  logic [DW-1:0] wdata [2];
  logic [DW-1:0] rd_o [2];
  logic [1:0]    drv_o [2];

  sync_dual_port_mem #(.ADDR_W(AW), .LANE_W(LW)) u0 (
    .rst_n(rst_n),
    .a_clk(clk), .a_cs0_n(cs0_n[0]), .a_cs1(cs1[0]), .a_we_n(we_n[0]), .a_addr(addr[0]),
    .a_wdata(wdata[0]), .a_lo_n(lo_n[0]), .a_hi_n(hi_n[0]), .a_oe_n(oe_n[0]), .a_pipe(pipe[0]),
    .a_rdata(rd_o[0]), .a_drv(drv_o[0]),
    .b_clk(clk), .b_cs0_n(cs0_n[1]), .b_cs1(cs1[1]), .b_we_n(we_n[1]), .b_addr(addr[1]),
    .b_wdata(wdata[1]), .b_lo_n(lo_n[1]), .b_hi_n(hi_n[1]), .b_oe_n(oe_n[1]), .b_pipe(pipe[1]),
    .b_rdata(rd_o[1]), .b_drv(drv_o[1])
  );

  // Bench model: contents, per-lane "value is defined" flags, output stages
  logic [DW-1:0] model [DEPTH];
  logic [1:0]    known [DEPTH];
  logic          e1v [2], e2v [2];
  logic [1:0]    e1l [2], e2l [2], e1k [2], e2k [2];
  logic [DW-1:0] e1w [2], e2w [2];
  int nchk = 0, nfail = 0;
  logic done = 1'b0;

  function automatic logic selected(int p);
    return (cs0_n[p] == 1'b0) && (cs1[p] == 1'b1);
  endfunction

  function automatic logic [1:0] lanes_of(int p);
    return {~hi_n[p], ~lo_n[p]};
  endfunction

  function automatic logic [1:0] exp_drive(int p);
    if (!rst_n || oe_n[p]) return 2'b00;
    if (pipe[p]) return e2v[p] ? e2l[p] : 2'b00;
    return e1v[p] ? e1l[p] : 2'b00;
  endfunction

  task automatic idle_port(int p);
    cs0_n[p] = 1'b1; cs1[p] = 1'b0; we_n[p] = 1'b1; lo_n[p] = 1'b0; hi_n[p] = 1'b0;
    addr[p] = '0; wdata[p] = '0;
  endtask

  task automatic set_port(int p, logic c0n, logic c1, logic wn, int a, logic [DW-1:0] d,
                          logic ln, logic hn);
    cs0_n[p] = c0n; cs1[p] = c1; we_n[p] = wn; addr[p] = AW'(a); wdata[p] = d;
    lo_n[p] = ln; hi_n[p] = hn;
  endtask

  task automatic check_port(int p, string tag);
    logic [1:0] ed;
    logic [1:0] kn;
    logic [DW-1:0] ew;
    ed = exp_drive(p);
    kn = pipe[p] ? e2k[p] : e1k[p];
    ew = pipe[p] ? e2w[p] : e1w[p];
    nchk++;
    if (drv_o[p] !== ed) begin
      nfail++;
      $display("FAIL %s port%0d drive actual=%b expected=%b t=%0t", tag, p, drv_o[p], ed, $time);
    end
    for (int l = 0; l < 2; l++) begin
      if (ed[l] && kn[l]) begin
        nchk++;
        if (rd_o[p][l*LW +: LW] !== ew[l*LW +: LW]) begin
          nfail++;
          $display("FAIL %s port%0d lane%0d data actual=%h expected=%h t=%0t", tag, p, l,
                   rd_o[p][l*LW +: LW], ew[l*LW +: LW], $time);
        end
      end
    end
  endtask

  // One clock: inputs were set before; model the edge, then check at the falling edge
  task automatic cycle(string tag);
    logic [1:0] wl [2];
    logic       wr [2];
    @(posedge clk);
    for (int p = 0; p < 2; p++) begin
      e2v[p] = e1v[p]; e2l[p] = e1l[p]; e2w[p] = e1w[p]; e2k[p] = e1k[p];
      if (!rst_n) begin
        e1v[p] = 1'b0; e1l[p] = 2'b00; e2v[p] = 1'b0; e2l[p] = 2'b00;
      end else begin
        e1v[p] = selected(p) && we_n[p];
        e1l[p] = e1v[p] ? lanes_of(p) : 2'b00;
        e1w[p] = model[addr[p]];
        e1k[p] = known[addr[p]];
      end
      wr[p] = selected(p) && !we_n[p];
      wl[p] = wr[p] ? lanes_of(p) : 2'b00;
    end
    // Writes land after both reads saw the old contents (R8)
    for (int p = 0; p < 2; p++) begin
      for (int l = 0; l < 2; l++) begin
        if (wl[p][l]) begin
          model[addr[p]][l*LW +: LW] = wdata[p][l*LW +: LW];
          known[addr[p]][l] = 1'b1;
        end
      end
    end
    // Same word, same lane, both ports: undefined result (R9)
    if (wr[0] && wr[1] && addr[0] == addr[1])
      known[addr[0]] = known[addr[0]] & ~(wl[0] & wl[1]);
    @(negedge clk);
    check_port(0, tag);
    check_port(1, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) known[i] = 2'b00;
    for (int p = 0; p < 2; p++) begin
      e1v[p] = 0; e2v[p] = 0; e1l[p] = 0; e2l[p] = 0; e1k[p] = 0; e2k[p] = 0;
      e1w[p] = '0; e2w[p] = '0;
      idle_port(p); oe_n[p] = 1'b0; pipe[p] = 1'b0;
    end

    // R10: reset state, no drive on either port
    repeat (2) cycle("R10 reset");
    @(negedge clk); rst_n = 1'b1;

    // R2/R8: both ports write at once, full words
    for (int i = 0; i < 8; i++) begin
      set_port(0, 0, 1, 0, i,     DW'(18'h10000 + i * 37), 0, 0);
      set_port(1, 0, 1, 0, i + 8, DW'(18'h2A000 + i * 53), 0, 0);
      cycle("R8 dual write");
    end
    // R3: direct reads on both ports, crossing the other port's words
    for (int i = 0; i < 8; i++) begin
      set_port(0, 0, 1, 1, i + 8, '0, 0, 0);
      set_port(1, 0, 1, 1, i,     '0, 0, 0);
      cycle("R3 direct read");
    end
    // R2: lower-lane-only then upper-lane-only write, read back
    set_port(0, 0, 1, 0, 1, DW'(18'h3FFFF), 0, 1); idle_port(1); cycle("R2 lane write");
    set_port(0, 0, 1, 0, 2, DW'(18'h3FFFF), 1, 0); cycle("R2 lane write");
    set_port(0, 0, 1, 1, 1, '0, 0, 0); cycle("R2 lane readback");
    set_port(0, 0, 1, 1, 2, '0, 0, 0); cycle("R2 lane readback");
    // R5: read with only the upper lane selected
    set_port(0, 0, 1, 1, 3, '0, 1, 0); cycle("R5 lane drive");
    set_port(0, 0, 1, 0, 4, DW'(18'h1234), 0, 0); cycle("R5 write no drive");
    // R1: each non-selecting combination must not write (addr 5 stays as before)
    set_port(0, 1, 1, 0, 5, DW'(18'h0BEEF), 0, 0); cycle("R1 deselect");
    set_port(0, 0, 0, 0, 5, DW'(18'h0BEEF), 0, 0); cycle("R1 deselect");
    set_port(0, 1, 0, 1, 5, '0, 0, 0); cycle("R1 deselect");
    set_port(0, 0, 1, 1, 5, '0, 0, 0); cycle("R1 readback");
    // R4: pipelined reads on B
    pipe[1] = 1'b1; idle_port(0);
    for (int i = 0; i < 6; i++) begin
      set_port(1, 0, 1, 1, i, '0, 0, 0); cycle("R4 piped read");
    end
    // R7: deselect one cycle then reactivate, piped and direct
    set_port(1, 1, 1, 1, 0, '0, 0, 0); cycle("R7 piped deselect");
    set_port(1, 0, 1, 1, 6, '0, 0, 0); cycle("R7 piped deselect");
    cycle("R7 piped reactivate");
    cycle("R7 piped reactivate");
    pipe[1] = 1'b0;
    set_port(1, 0, 0, 1, 0, '0, 0, 0); cycle("R7 direct deselect");
    set_port(1, 0, 1, 1, 7, '0, 0, 0); cycle("R7 direct reactivate");
    // R8: read of a word the other port writes on the same edge returns old data
    set_port(0, 0, 1, 0, 3, DW'(18'h15555), 0, 0);
    set_port(1, 0, 1, 1, 3, '0, 0, 0); cycle("R8 read during write");
    idle_port(0); cycle("R8 new data next access");
    // R9: same word, disjoint lanes, both defined; then overlapping lanes, undefined
    set_port(0, 0, 1, 0, 9, DW'(18'h000AA), 0, 1);
    set_port(1, 0, 1, 0, 9, DW'(18'h2AA00), 1, 0); cycle("R9 split lanes");
    set_port(0, 0, 1, 1, 9, '0, 0, 0); idle_port(1); cycle("R9 split readback");
    set_port(0, 0, 1, 0, 10, DW'(18'h11111), 0, 0);
    set_port(1, 0, 1, 0, 10, DW'(18'h22222), 0, 1); cycle("R9 clash");
    set_port(0, 0, 1, 1, 10, '0, 0, 0); idle_port(1); cycle("R9 clash readback");
    // R6: output enable acts between edges
    set_port(0, 0, 1, 1, 8, '0, 0, 0); cycle("R6 setup");
    oe_n[0] = 1'b1; #0.5; check_port(0, "R6 oe off");
    oe_n[0] = 1'b0; #0.5; check_port(0, "R6 oe on");

    // Mixed random traffic on a narrow address range
    for (int blk = 0; blk < 40; blk++) begin
      pipe[0] = 1'($urandom % 2); pipe[1] = 1'($urandom % 2);
      for (int c = 0; c < 64; c++) begin
        for (int p = 0; p < 2; p++) begin
          int r;
          r = int'($urandom % 8);
          set_port(p, (r == 6), (r != 7), 1'($urandom % 2), int'($urandom % 16),
                   DW'($urandom), 1'($urandom % 4 == 0), 1'($urandom % 4 == 0));
          oe_n[p] = ($urandom % 8 == 0);
        end
        cycle("R3 R4 R5 R8 random");
      end
    end

    // R10: reset mid-run clears drive immediately
    for (int p = 0; p < 2; p++) begin
      set_port(p, 0, 1, 1, p, '0, 0, 0); oe_n[p] = 1'b0;
    end
    cycle("R10 pre-reset");
    for (int p = 0; p < 2; p++) idle_port(p);
    rst_n = 1'b0; #0.5;
    check_port(0, "R10 async reset");
    check_port(1, "R10 async reset");
    cycle("R10 in reset");
    rst_n = 1'b1;
    cycle("R10 after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule